// File: doc/BRIEF.md
# PLL Output Divider Configuration with Lock Guard

This block keeps the settings of a phase-locked loop: a 9-bit feedback multiplier code and three 7-bit post-divider codes, called P, Q and R here. Every code is stored as the factor minus one. Software writes all four fields in a single 32-bit word and reads them back from the same word. The block refuses codes that are not legal. It also refuses every write while the loop is enabled or reports lock, so the settings cannot change under a running oscillator.

The same block divides the VCO-rate clock `clk` into three slower clocks, each paired with a one-cycle enable pulse. The counters stay cleared while the loop reports not ready. They start from zero when ready rises, so a divided clock always starts cleanly with the divisor last latched. Even divisors give a 50% duty cycle. A Q or R code of 0 passes the input clock straight through.

A rejected field sets a sticky error bit. Reading the word clears that bit.

Top module: `pll_postdiv_cfg`

## Requirements
- R1: After reset the word reads multiplier code 128 in bits [8:0], P code 1 in bits [15:9], Q code 1 in bits [22:16], R code 1 in bits [29:23], error bit [31] = 0, and bit [30] = 0.
- R2: A write stores a multiplier code from 3 to 511. A code of 0, 1 or 2 leaves the stored multiplier unchanged.
- R3: A write stores a P code only if it is odd (bit 0 = 1). Even codes, 0 included, leave the stored P code unchanged. Q and R accept any code.
- R4: An accepted write that carries a refused multiplier or P code sets error bit [31]. A read pulse clears it at the next edge. When a refused write and a read happen in the same cycle, the bit is set.
- R5: While `pll_on` or `pll_rdy` is 1, a write changes no field and does not touch the error bit.
- R6: While `pll_rdy` is 1, `q_en` and `r_en` pulse once every code+1 cycles. Code 0 holds the enable high in every cycle.
- R7: While `pll_rdy` is 1, `p_en` pulses once every P code+1 cycles.
- R8: While `pll_rdy` is 0, all enables and divided clocks are 0. After `pll_rdy` rises, the first enable pulse comes after code clock edges (for code 0 it comes at once).
- R9: For an even divisor N, each divided clock is high for exactly N/2 of the N cycles of every period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO-rate clock; also clocks the register port |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 32 | Configuration word to write |
| rd_en | input | 1 | Read strobe; clears the error bit |
| rd_data | output | 32 | Current configuration word and error bit |
| pll_on | input | 1 | Loop enable status |
| pll_rdy | input | 1 | Loop ready (lock) status |
| p_en | output | 1 | One-cycle pulse per P period |
| q_en | output | 1 | One-cycle pulse per Q period |
| r_en | output | 1 | One-cycle pulse per R period |
| p_clk | output | 1 | P divided clock |
| q_clk | output | 1 | Q divided clock |
| r_clk | output | 1 | R divided clock |

## Verification
The hardest case to reach is the timing of every divider code. Each output must be measured at each of its legal codes, which means many write, lock and release cycles one after another. The bench sweeps all 128 Q/R codes and all 64 odd P codes. For each code it releases ready, writes the code, raises ready again, and measures the first-pulse delay, the period and the high time. Random writes with random enable and ready levels then exercise the lock rule and the error bit against a model kept in the bench.

// File: rtl/pll_postdiv_cfg.sv
module pll_postdiv_cfg #(
  parameter int MW       = 9,
  parameter int DW       = 7,
  parameter int MULT_MIN = 3,
  parameter int MULT_RST = 128,
  parameter int DIV_RST  = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  output logic [31:0] rd_data,
  input  logic        pll_on,
  input  logic        pll_rdy,
  output logic        p_en,
  output logic        q_en,
  output logic        r_en,
  output logic        p_clk,
  output logic        q_clk,
  output logic        r_clk
);
  localparam int P_LO = MW;
  localparam int Q_LO = P_LO + DW;
  localparam int R_LO = Q_LO + DW;
  localparam int PAD  = 31 - (R_LO + DW);

  logic [MW-1:0] mult_q;
  logic [DW-1:0] code [3];
  logic          err_q;

  wire           unlocked = !pll_on && !pll_rdy;
  wire           wr_ok    = wr_en && unlocked;
  wire [MW-1:0]  new_m    = wr_data[0 +: MW];
  wire [DW-1:0]  new_p    = wr_data[P_LO +: DW];
  wire           m_ok     = new_m >= MW'(MULT_MIN);
  wire           p_ok     = new_p[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult_q  <= MW'(MULT_RST);
      code[0] <= DW'(DIV_RST);
      code[1] <= DW'(DIV_RST);
      code[2] <= DW'(DIV_RST);
    end else if (wr_ok) begin
      if (m_ok) mult_q  <= new_m;
      if (p_ok) code[0] <= new_p;
      code[1] <= wr_data[Q_LO +: DW];
      code[2] <= wr_data[R_LO +: DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        err_q <= 1'b0;
    else if (wr_ok && !(m_ok && p_ok)) err_q <= 1'b1;
    else if (rd_en)                    err_q <= 1'b0;
  end

  assign rd_data = {err_q, {PAD{1'b0}}, code[2], code[1], code[0], mult_q};

  logic [2:0] en_v, dclk_v;

  for (genvar g = 0; g < 3; g++) begin : g_div
    logic [DW-1:0] cnt;
    wire  [DW:0]   half = ({1'b0, code[g]} + 1'b1) >> 1;
    wire           wrap = cnt >= code[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (!pll_rdy) cnt <= '0;
      else if (wrap)     cnt <= '0;
      else               cnt <= cnt + 1'b1;
    end

    assign en_v[g]   = pll_rdy && (cnt == code[g]);
    assign dclk_v[g] = pll_rdy && ((code[g] == '0) ? clk : ({1'b0, cnt} < half));
  end

  assign p_en  = en_v[0];
  assign q_en  = en_v[1];
  assign r_en  = en_v[2];
  assign p_clk = dclk_v[0];
  assign q_clk = dclk_v[1];
  assign r_clk = dclk_v[2];

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_on || pll_rdy) |=> $stable(rd_data[30:0]));                    // R5
  AST_LOCK_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ((pll_on || pll_rdy) && !rd_en) |=> $stable(err_q));                // R5
  AST_MULT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[MW-1:0] >= MW'(MULT_MIN));                                  // R2
  AST_P_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[P_LO]);                                                     // R3
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && unlocked && !new_m[MW-1:2] && new_m[1:0] != 2'b11) |=> rd_data[31]); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_rdy |-> (en_v == 3'b000));                                     // R8
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_rdy && p_en && code[0] != '0 && $stable(pll_rdy)) |=> !p_en);  // R7
endmodule

// File: tb/pll_postdiv_cfg_tb.sv
module pll_postdiv_cfg_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, pll_on = 1'b0, pll_rdy = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic p_en, q_en, r_en, p_clk, q_clk, r_clk;

  int checks = 0, fails = 0, cycles = 0;
  logic [8:0] m_mult;
  logic [6:0] m_p, m_q, m_r;
  logic       m_err;

  always #4 clk = ~clk;

  pll_postdiv_cfg dut_i (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 200000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word();
    return {m_err, 1'b0, m_r, m_q, m_p, m_mult};
  endfunction

  function automatic logic [31:0] mk(input int m, input int p, input int q, input int r);
    return {2'b00, 7'(r), 7'(q), 7'(p), 9'(m)};
  endfunction

  task automatic write_word(input logic [31:0] w);
    logic m_ok, p_ok;
    m_ok = w[8:0] >= 9'd3;
    p_ok = w[9];
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
    if (!pll_on && !pll_rdy) begin
      if (m_ok) m_mult = w[8:0];
      if (p_ok) m_p = w[15:9];
      m_q = w[22:16];
      m_r = w[29:23];
      if (!(m_ok && p_ok)) m_err = 1'b1;
    end
  endtask

  task automatic read_clear(input string req);
    chk(req, rd_data, exp_word());
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    m_err = 1'b0;
  endtask

  function automatic logic en_of(input int sel);
    return sel == 0 ? p_en : (sel == 1 ? q_en : r_en);
  endfunction
  function automatic logic dclk_of(input int sel);
    return sel == 0 ? p_clk : (sel == 1 ? q_clk : r_clk);
  endfunction

  task automatic meas(input int sel, input int c);
    int k, n, hi;
    string rq;
    rq = (sel == 0) ? "R7" : "R6";
    pll_rdy = 1'b0; pll_on = 1'b1;
    @(negedge clk);
    chk("R8 idle", {en_of(sel), dclk_of(sel)}, 0);
    pll_rdy = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!en_of(sel) && k < 300);
    chk("R8 first pulse", k, (c == 0) ? 1 : c);
    n = 0; hi = 0;
    do begin @(negedge clk); n++; hi += int'(dclk_of(sel)); end while (!en_of(sel) && n < 300);
    chk(rq, n, c + 1);
    if ((c + 1) % 2 == 0) chk("R9", hi, (c + 1) / 2);
    pll_rdy = 1'b0; pll_on = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    m_mult = 9'd128; m_p = 7'd1; m_q = 7'd1; m_r = 7'd1; m_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", rd_data, 32'h0081_0280);
    chk("R1 model", rd_data, exp_word());

    write_word(mk(2, 1, 1, 1));
    chk("R2 code 2 refused", rd_data, exp_word());
    chk("R4 err set", rd_data[31], 1);
    read_clear("R4 read");
    chk("R4 err cleared", rd_data[31], 0);
    write_word(mk(0, 3, 1, 1)); read_clear("R2 code 0");
    write_word(mk(3, 1, 1, 1)); chk("R2 min accepted", rd_data[8:0], 3);
    write_word(mk(511, 1, 1, 1)); chk("R2 max accepted", rd_data[8:0], 511);
    write_word(mk(128, 0, 5, 6)); chk("R3 P=0 refused, Q/R taken", rd_data, exp_word());
    read_clear("R3 read");
    write_word(mk(128, 2, 1, 1)); chk("R3 P=2 refused", rd_data[15:9], m_p);
    wr_en = 1'b1; wr_data = mk(1, 1, 1, 1); rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R4 set wins over clear", rd_data[31], 1);
    read_clear("R4 clear");
    pll_on = 1'b1;
    write_word(mk(300, 9, 9, 9)); chk("R5 on blocks write", rd_data, exp_word());
    write_word(mk(0, 0, 9, 9)); chk("R5 on no err", rd_data[31], 0);
    pll_on = 1'b0; pll_rdy = 1'b1;
    write_word(mk(300, 9, 9, 9)); chk("R5 rdy blocks write", rd_data, exp_word());
    pll_rdy = 1'b0;

    for (int i = 0; i < 128; i++) begin
      write_word(mk(128, i | 1, i, 127 - i));
      chk("R6 setup", rd_data, exp_word());
      meas(1, i);
      meas(2, 127 - i);
      if (i % 2 == 1) meas(0, i);
    end

    for (int it = 0; it < 400; it++) begin
      logic [31:0] w;
      w = $urandom;
      if ($urandom % 4 == 0) w[8:2] = '0;
      case ($urandom % 4)
        0: begin pll_on = 1'b1; pll_rdy = 1'b0; end
        1: begin pll_on = 1'b1; pll_rdy = 1'b1; end
        default: begin pll_on = 1'b0; pll_rdy = 1'b0; end
      endcase
      write_word(w);
      chk(pll_on ? "R5 random" : "R2 R3 R4 random", rd_data, exp_word());
      if ($urandom % 3 == 0) read_clear("R4 random read");
    end
    pll_on = 1'b0; pll_rdy = 1'b0;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule